// File: doc/BRIEF.md
# Octave Delay-Line Memory Controller

This block sits between a folded multirate filter engine and a single-port data RAM. The RAM holds one circular delay line per octave. Each line is 41 words of 16 bits, and there are six lines. One line serves all the filters of its octave, because those filters all have an odd tap count and can share the same sample history. Each cycle the engine issues at most one command. The block turns that command into the RAM enable, write strobe, flat address and write word, or into a coefficient ROM enable and address.

Two write sources feed the lines. A fresh input sample always goes into the first octave's line. A decimated result from octave j goes into the line of octave j+1. A linear-phase filter reads its history in mirrored pairs. For tap index k, one command reads the newest-minus-k word and another reads the word at the opposite end of the window. The centre tap is read only once. The RAM and the coefficient ROM are never enabled in the same cycle. Whichever memory is idle sees its address and data inputs frozen, so it does not toggle.

The RAM is modelled as a plain synchronous array inside the block. Scheduling of octaves and all arithmetic belong to other blocks.

Top module: `octave_delay_ctrl`

## Requirements
- R1: After reset, rd_valid, ram_en and rom_en are 0, ram_addr and rom_addr are 0, and the first write into line L lands at flat address L*41.
- R2: Command code 1 (input push) writes in_sample into line 0 whatever cmd_line holds, with ram_en=1 and ram_we=1 in the same cycle.
- R3: Command code 2 (decimated push) with cmd_line=j for j from 0 to 4 writes dec_sample into line j+1. With j of 5 or more, the command makes no RAM access and changes no line.
- R4: Each line is a ring with its own head. Every write to a line advances that line's head by one and wraps after slot 40. Writes to other lines leave it untouched.
- R5: Command code 3 (near read) with tap k from 0 to 20 reads slot (head-k) mod 41 of line cmd_line. The word appears on rd_data with rd_valid=1 in the cycle after the command.
- R6: Command code 4 (far read) with tap k from 0 to 19 reads slot (head-(40-k)) mod 41 of line cmd_line, with the same one-cycle latency.
- R7: A far read at k=20 (the centre tap) makes no access and raises no rd_valid. A near read with k>20, or a far read with k>20, is ignored in the same way.
- R8: Command code 5 (coefficient fetch) drives rom_en=1 and rom_addr=coef_idx in the same cycle, with ram_en=0.
- R9: ram_en and rom_en are never 1 together. While ram_en is 0, ram_addr and ram_wdata keep their last driven values, and while rom_en is 0, rom_addr keeps its last value. ram_wdata also holds its value during reads.
- R10: The flat RAM address is line*41+slot, and ram_we is 1 only for the two write commands.
- R11: Command codes 0, 6 and 7, and reads naming a line above 5, make no access to either memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command code for this cycle |
| cmd_line | input | 3 | Line index (read target, or finished octave for a decimated push) |
| cmd_tap | input | 6 | Tap index k for reads |
| coef_idx | input | 7 | Coefficient word index for a fetch |
| in_sample | input | 16 | New input sample for line 0 |
| dec_sample | input | 16 | Decimated result for the next line |
| ram_en | output | 1 | Data RAM access this cycle |
| ram_we | output | 1 | Data RAM write strobe |
| ram_addr | output | 8 | Flat data RAM address, held when idle |
| ram_wdata | output | 16 | Data RAM write word, held when not writing |
| rom_en | output | 1 | Coefficient ROM access this cycle |
| rom_addr | output | 7 | Coefficient ROM address, held when idle |
| rd_data | output | 16 | Word read from the delay line |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |

## Verification
The assertions assume that commands arrive only while reset is released, and at most one per clock edge, each held stable across that edge. They also assume that any line read has already been filled at least once. Without that, a read could return a word never written, which no check can predict. The stimulus changes inputs only on the falling edge and issues exactly one command per cycle. It fills every line past one full wrap before any read, and it places ignored and out-of-range commands between real ones. A stray access or a lost hold therefore shows up as a changed port value, or as an extra or missing read result.

// File: rtl/dlmc_pkg.sv
package dlmc_pkg;

    localparam int DEF_LINES = 6;
    localparam int DEF_LEN   = 41;
    localparam int DEF_DW    = 16;
    localparam int DEF_CAW   = 7;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_IN   = 3'd1,
        OP_DEC  = 3'd2,
        OP_NEAR = 3'd3,
        OP_FAR  = 3'd4,
        OP_COEF = 3'd5
    } op_e;

endpackage

// File: rtl/dlmc_ring_sub.sv
module dlmc_ring_sub #(
    parameter int LEN = dlmc_pkg::DEF_LEN
) (
    input  logic [$clog2(LEN)-1:0] base,
    input  logic [$clog2(LEN)-1:0] offset,
    output logic [$clog2(LEN)-1:0] slot
);
    localparam int SW = $clog2(LEN);

    // modular subtraction on a ring of LEN slots
    always_comb begin
        if (base >= offset) begin
            slot = base - offset;
        end else begin
            slot = SW'(int'(base) + LEN - int'(offset));
        end
    end

endmodule

// File: rtl/dlmc_heads.sv
module dlmc_heads #(
    parameter int NUM_LINES = dlmc_pkg::DEF_LINES,
    parameter int LEN       = dlmc_pkg::DEF_LEN
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]               wr_line,
    output logic [NUM_LINES-1:0][$clog2(LEN)-1:0]      heads
);
    localparam int SW = $clog2(LEN);

    logic [NUM_LINES-1:0][SW-1:0] head_d, head_q;

    always_comb begin
        head_d = head_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en && int'(wr_line) == i) begin
                head_d[i] = (int'(head_q[i]) == LEN - 1) ? '0 : head_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                head_q[i] <= SW'(LEN - 1);
            end
        end else begin
            head_q <= head_d;
        end
    end

    assign heads = head_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
        // R4: a line not written this cycle keeps its head
        assert_idle_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(wr_line) == g) |=> $stable(heads[g]));
        // R4: head always names a real slot
        assert_head_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(heads[g]) < LEN);
    end

endmodule

// File: rtl/dlmc_ram.sv
module dlmc_ram #(
    parameter int DEPTH = dlmc_pkg::DEF_LINES * dlmc_pkg::DEF_LEN,
    parameter int DW    = dlmc_pkg::DEF_DW
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end else begin
                rdata <= mem_q[addr];
            end
        end
    end

endmodule

// File: rtl/octave_delay_ctrl.sv
module octave_delay_ctrl #(
    parameter int NUM_LINES = dlmc_pkg::DEF_LINES,
    parameter int LINE_LEN  = dlmc_pkg::DEF_LEN,
    parameter int DATA_W    = dlmc_pkg::DEF_DW,
    parameter int COEF_AW   = dlmc_pkg::DEF_CAW
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [2:0]                               cmd_op,
    input  logic [$clog2(NUM_LINES)-1:0]             cmd_line,
    input  logic [$clog2(LINE_LEN)-1:0]              cmd_tap,
    input  logic [COEF_AW-1:0]                       coef_idx,
    input  logic [DATA_W-1:0]                        in_sample,
    input  logic [DATA_W-1:0]                        dec_sample,
    output logic                                     ram_en,
    output logic                                     ram_we,
    output logic [$clog2(NUM_LINES*LINE_LEN)-1:0]    ram_addr,
    output logic [DATA_W-1:0]                        ram_wdata,
    output logic                                     rom_en,
    output logic [COEF_AW-1:0]                       rom_addr,
    output logic [DATA_W-1:0]                        rd_data,
    output logic                                     rd_valid
);
    import dlmc_pkg::*;

    localparam int SLOT_W  = $clog2(LINE_LEN);
    localparam int LINE_W  = $clog2(NUM_LINES);
    localparam int DEPTH   = NUM_LINES * LINE_LEN;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int TAP_MAX = (LINE_LEN - 1) / 2;

    typedef struct packed {
        logic              ram_en;
        logic              ram_we;
        logic              from_in;
        logic [LINE_W-1:0] line;
        logic [SLOT_W-1:0] off;
        logic              rom_en;
    } acc_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  ram_addr;
        logic [DATA_W-1:0]  wdata;
        logic [COEF_AW-1:0] rom_addr;
        logic               rd_valid;
    } state_t;

    acc_t   acc;
    state_t st_d, st_q;

    logic [NUM_LINES-1:0][SLOT_W-1:0] heads_w;
    logic [SLOT_W-1:0]                slot_w;
    logic [ADDR_W-1:0]                flat_w;
    logic [DATA_W-1:0]                wsel_w;

    // command decode: at most one memory touched per cycle
    always_comb begin
        acc = '0;
        if (rst_n) begin
            case (cmd_op)
                OP_IN: begin
                    acc.ram_en  = 1'b1;
                    acc.ram_we  = 1'b1;
                    acc.from_in = 1'b1;
                    acc.line    = '0;
                    acc.off     = SLOT_W'(LINE_LEN - 1);
                end
                OP_DEC: begin
                    if (int'(cmd_line) < NUM_LINES - 1) begin
                        acc.ram_en = 1'b1;
                        acc.ram_we = 1'b1;
                        acc.line   = cmd_line + LINE_W'(1);
                        acc.off    = SLOT_W'(LINE_LEN - 1);
                    end
                end
                OP_NEAR: begin
                    if (int'(cmd_line) < NUM_LINES && int'(cmd_tap) <= TAP_MAX) begin
                        acc.ram_en = 1'b1;
                        acc.line   = cmd_line;
                        acc.off    = cmd_tap;
                    end
                end
                OP_FAR: begin
                    if (int'(cmd_line) < NUM_LINES && int'(cmd_tap) < TAP_MAX) begin
                        acc.ram_en = 1'b1;
                        acc.line   = cmd_line;
                        acc.off    = SLOT_W'(LINE_LEN - 1) - cmd_tap;
                    end
                end
                OP_COEF: begin
                    acc.rom_en = 1'b1;
                end
                default: ;
            endcase
        end
    end

    dlmc_heads #(
        .NUM_LINES (NUM_LINES),
        .LEN       (LINE_LEN)
    ) u_heads (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc.ram_en && acc.ram_we),
        .wr_line (acc.line),
        .heads   (heads_w)
    );

    // writes land one past head, i.e. head - (LEN-1) on the ring
    dlmc_ring_sub #(
        .LEN (LINE_LEN)
    ) u_sub (
        .base   (heads_w[acc.line]),
        .offset (acc.off),
        .slot   (slot_w)
    );

    assign flat_w = ADDR_W'(int'(acc.line) * LINE_LEN + int'(slot_w));
    assign wsel_w = acc.from_in ? in_sample : dec_sample;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = acc.ram_en && !acc.ram_we;
        if (acc.ram_en) begin
            st_d.ram_addr = flat_w;
        end
        if (acc.ram_en && acc.ram_we) begin
            st_d.wdata = wsel_w;
        end
        if (acc.rom_en) begin
            st_d.rom_addr = coef_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dlmc_ram #(
        .DEPTH (DEPTH),
        .DW    (DATA_W)
    ) u_ram (
        .clk   (clk),
        .en    (acc.ram_en),
        .we    (acc.ram_we),
        .addr  (flat_w),
        .wdata (wsel_w),
        .rdata (rd_data)
    );

    assign ram_en    = acc.ram_en;
    assign ram_we    = acc.ram_we;
    assign ram_addr  = st_d.ram_addr;
    assign ram_wdata = st_d.wdata;
    assign rom_en    = acc.rom_en;
    assign rom_addr  = st_d.rom_addr;
    assign rd_valid  = st_q.rd_valid;

    assert_one_memory_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && rom_en));

    assert_ram_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> $stable(ram_addr));

    assert_rom_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_en |-> $stable(rom_addr));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> rd_valid);

    assert_centre_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_FAR && int'(cmd_tap) == TAP_MAX) |=> !rd_valid);

    assert_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> int'(ram_addr) < DEPTH);

    assert_dec_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_DEC && ram_we) |-> int'(ram_addr) >= (int'(cmd_line) + 1) * LINE_LEN);

endmodule

// File: tb/sim_octave_delay_ctrl.sv
module sim_octave_delay_ctrl;

    logic        clk;
    logic        rst_n;
    logic [2:0]  cmd_op;
    logic [2:0]  cmd_line;
    logic [5:0]  cmd_tap;
    logic [6:0]  coef_idx;
    logic [15:0] in_sample;
    logic [15:0] dec_sample;
    logic        ram_en, ram_we, rom_en, rd_valid;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata, rd_data;
    logic [6:0]  rom_addr;

    octave_delay_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_line),
        .cmd_tap    (cmd_tap),
        .coef_idx   (coef_idx),
        .in_sample  (in_sample),
        .dec_sample (dec_sample),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .rom_en     (rom_en),
        .rom_addr   (rom_addr),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int          stamp;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [15:0] m [6][41];
    int          h [6];
    int          last_addr = 0;
    int          last_rom  = 0;
    logic [15:0] last_wd   = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one command per cycle, model updated, read results queued
    task automatic issue(input logic [2:0] op, input int line, input int tap,
                         input int coef, input logic [15:0] ins,
                         input logic [15:0] decs, input string req);
        bit          e_en = 0, e_we = 0, e_rom = 0;
        int          e_addr = last_addr;
        int          e_romaddr = last_rom;
        logic [15:0] e_wd = last_wd;
        int          slot;
        exp_t        it;
        @(negedge clk);
        cmd_op     = op;
        cmd_line   = line[2:0];
        cmd_tap    = tap[5:0];
        coef_idx   = coef[6:0];
        in_sample  = ins;
        dec_sample = decs;
        case (op)
            3'd1: begin
                h[0] = (h[0] + 1) % 41;
                m[0][h[0]] = ins;
                e_en = 1; e_we = 1; e_addr = h[0]; e_wd = ins;
            end
            3'd2: if (line < 5) begin
                h[line+1] = (h[line+1] + 1) % 41;
                m[line+1][h[line+1]] = decs;
                e_en = 1; e_we = 1; e_addr = (line + 1) * 41 + h[line+1]; e_wd = decs;
            end
            3'd3: if (line < 6 && tap <= 20) begin
                slot = (h[line] - tap + 41) % 41;
                e_en = 1; e_addr = line * 41 + slot;
                it.stamp = cyc; it.val = m[line][slot]; it.req = req;
                q.push_back(it);
            end
            3'd4: if (line < 6 && tap < 20) begin
                slot = (h[line] - (40 - tap) + 41) % 41;
                e_en = 1; e_addr = line * 41 + slot;
                it.stamp = cyc; it.val = m[line][slot]; it.req = req;
                q.push_back(it);
            end
            3'd5: begin
                e_rom = 1; e_romaddr = coef;
            end
            default: ;
        endcase
        #1;
        chk(ram_en == e_en, req, "ram_en", 32'(ram_en), 32'(e_en));
        chk(ram_we == e_we, req, "ram_we", 32'(ram_we), 32'(e_we));
        chk(int'(ram_addr) == e_addr, req, "ram_addr", 32'(ram_addr), 32'(e_addr));
        chk(ram_wdata == e_wd, req, "ram_wdata", 32'(ram_wdata), 32'(e_wd));
        chk(rom_en == e_rom, req, "rom_en", 32'(rom_en), 32'(e_rom));
        chk(int'(rom_addr) == e_romaddr, req, "rom_addr", 32'(rom_addr), 32'(e_romaddr));
        last_addr = e_addr;
        last_rom  = e_romaddr;
        last_wd   = e_wd;
    endtask

    // monitor: read results must match queued expectations in order
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].stamp < cyc) begin
                chk(rd_valid === 1'b1, q[0].req, "rd_valid", 32'(rd_valid), 32'd1);
                if (rd_valid === 1'b1)
                    chk(rd_data === q[0].val, q[0].req, "rd_data", 32'(rd_data), 32'(q[0].val));
                void'(q.pop_front());
            end else if (rd_valid !== 1'b0) begin
                chk(1'b0, "R7/R11", "unexpected rd_valid", 32'(rd_valid), 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) h[i] = 40;
        rst_n = 1'b0; cmd_op = '0; cmd_line = '0; cmd_tap = '0;
        coef_idx = '0; in_sample = '0; dec_sample = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk(ram_en == 1'b0, "R1", "ram_en", 32'(ram_en), 32'd0);
        chk(rom_en == 1'b0, "R1", "rom_en", 32'(rom_en), 32'd0);
        chk(ram_addr == '0, "R1", "ram_addr", 32'(ram_addr), 32'd0);
        chk(rom_addr == '0, "R1", "rom_addr", 32'(rom_addr), 32'd0);

        // R1/R2/R4/R10: input pushes with cmd_line varied, wrapping the ring
        for (int n = 0; n < 50; n++)
            issue(3'd1, n % 8, 0, 0, 16'h1000 + 16'(n), 16'hdead, "R1/R2/R4/R10");
        // R3/R4: decimated pushes into lines 1..5, different counts per line
        for (int j = 0; j < 5; j++)
            for (int n = 0; n < 41 + 3 * j; n++)
                issue(3'd2, j, 0, 0, 16'hbeef, 16'h2000 + 16'(j * 256 + n), "R1/R3/R4");
        // R3: no next line for the last octave
        issue(3'd2, 5, 0, 0, 16'h0, 16'h7777, "R3");
        issue(3'd2, 7, 0, 0, 16'h0, 16'h7778, "R3");
        // R8 then R9 hold, R11 ignored codes
        issue(3'd5, 0, 0, 77, 16'h0, 16'h0, "R8");
        issue(3'd0, 0, 0, 12, 16'h0, 16'h0, "R9");
        issue(3'd6, 1, 2, 13, 16'h0, 16'h0, "R11");
        issue(3'd7, 1, 2, 14, 16'h0, 16'h0, "R11");
        // R5/R6/R7: every tap pair on every line
        for (int l = 0; l < 6; l++)
            for (int k = 0; k <= 20; k++) begin
                issue(3'd3, l, k, 0, 16'h0, 16'h0, "R5");
                issue(3'd4, l, k, 0, 16'h0, 16'h0, "R6/R7");
            end
        issue(3'd3, 2, 25, 0, 16'h0, 16'h0, "R7");
        issue(3'd4, 2, 33, 0, 16'h0, 16'h0, "R7");
        issue(3'd3, 6, 0, 0, 16'h0, 16'h0, "R11");
        issue(3'd4, 7, 1, 0, 16'h0, 16'h0, "R11");
        // interleaved traffic
        for (int n = 0; n < 10; n++) begin
            issue(3'd1, 0, 0, 0, 16'h3000 + 16'(n), 16'h0, "R4");
            issue(3'd3, 0, 0, 0, 16'h0, 16'h0, "R5");
            issue(3'd5, 0, 0, n, 16'h0, 16'h0, "R9");
            issue(3'd4, 0, 3, 0, 16'h0, 16'h0, "R6");
            issue(3'd2, n % 5, 0, 0, 16'h0, 16'h4000 + 16'(n), "R3");
            issue(3'd3, n % 5 + 1, 1, 0, 16'h0, 16'h0, "R5");
            issue(3'd4, n % 5 + 1, 19, 0, 16'h0, 16'h0, "R6");
        end
        issue(3'd0, 0, 0, 0, 16'h0, 16'h0, "R9");
        repeat (3) @(negedge clk);
        #1;
        chk(q.size() == 0, "R5/R6", "pending reads", 32'(q.size()), 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule